// File: doc/BRIEF.md
# Interrupt Line Request and EOI Tracker

This block holds the per-pin request state of an interrupt redirection controller. Every clock it samples the raw interrupt lines and applies each entry's polarity, trigger mode and mask. It keeps one request bit per pin, plus a remote-IRR bit for level-triggered pins. From these it picks at most one pin per cycle to service. For a serviced pin that is unmasked, it emits a single-cycle deliver pulse carrying the pin index. Destination resolution and message formatting happen downstream.

Edge-triggered pins produce one delivery for each rise of their effective level. Their request bit clears once they are serviced, whether or not the pin is masked. A level-triggered pin sets its remote-IRR bit when it is delivered, and stays quiet until an end-of-interrupt arrives whose vector matches its entry. If the line is still asserted when that EOI clears the bit, the pin is delivered again. The register window can also issue a service strobe for one pin.

Top module: `irq_req_tracker`

## Requirements
- R1: The effective level of a pin is its raw line XOR its polarity bit (polarity 1 inverts). A rise of the effective level caused by a polarity change counts like a rise of the line.
- R2: While a pin's effective level is low its request bit is cleared. A level pin whose line dropped before its EOI is therefore not delivered again after the EOI.
- R3: An edge-triggered pin (trigger bit 0) gives exactly one delivery per rise of its effective level. Holding the line high produces no further delivery.
- R4: Servicing a masked edge-triggered pin (mask bit 1) clears its request without a delivery. Unmasking it afterwards delivers nothing.
- R5: Delivering a level-triggered pin (trigger bit 1) sets its remote-IRR bit. While that bit is set, a held-high line produces no further delivery.
- R6: A masked level-triggered pin with its line asserted stays pending. It is delivered once it is unmasked.
- R7: An EOI clears remote-IRR only in the lowest-index entry whose vector field equals the EOI vector. If that entry is unmasked and its request bit is still set, it is delivered again.
- R8: An EOI whose vector matches no entry changes nothing.
- R9: When several pins need service in the same cycle, the lowest index is delivered first and the rest stay pending. At most one delivery happens per cycle.
- R10: A service strobe for an in-range pin whose request bit is set services that pin as a new rising request. An unmasked level pin is delivered even if its remote-IRR bit is set.
- R11: A service strobe naming a pin number at or above the pin count is ignored.
- R12: The deliver pulse lasts one cycle and carries the serviced pin index. It follows the registered request by one clock when the output register is enabled. After reset no request, remote-IRR or delivery is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | NPIN | Raw interrupt line levels |
| pol_i | input | NPIN | Per-pin polarity, 1 = active low |
| trig_level_i | input | NPIN | Per-pin trigger mode, 1 = level, 0 = edge |
| mask_i | input | NPIN | Per-pin mask, 1 = masked |
| vec_i | input | NPIN*VEC_W | Per-pin vector fields, pin i at bits i*VEC_W upward |
| eoi_valid_i | input | 1 | End-of-interrupt message present this cycle |
| eoi_vec_i | input | VEC_W | Vector carried by the EOI |
| svc_strobe_i | input | 1 | Service request from the register window |
| svc_pin_i | input | PIN_W | Pin addressed by the service strobe |
| dlv_valid_o | output | 1 | Single-cycle deliver request |
| dlv_pin_o | output | PIN_W | Pin index being delivered |

## Verification
The bench drives a level pin through delivery, a held line, a matching EOI and a dropped line. A design that forgets remote-IRR then floods deliveries, and one that keeps stale requests redelivers after the line drops. Two level entries share one vector so that an EOI must release only the lower index; a design that clears every match delivers both. Masked edge and level pins check that an edge request is discarded and a level request is held. Simultaneous rises and out-of-range service strobes check the priority order and the pin range check: a truncated pin compare would wrongly service an aliased pin that has its request set.

// File: rtl/irt_pkg.sv
package irt_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;
endpackage

// File: rtl/irt_lowest_pick.sv
module irt_lowest_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

   assign onehot = req & (~req + N'(1));
endmodule

// File: rtl/irt_line_cell.sv
module irt_line_cell
   import irt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic pol,
   input  logic lvl_mode,
   input  logic mask,
   input  logic svc_hit,
   input  logic grant,
   input  logic eoi_clr,
   output logic cand,
   output logic req,
   output logic rirr
);
   logic eff, eff_q, rise, is_lvl;
   logic req_d, rirr_d;

   assign is_lvl = (trig_e'(lvl_mode) == TRIG_LEVEL);
   assign eff    = raw ^ pol;
   assign rise   = eff & ~eff_q;

   // level pins wait for remote-IRR to clear unless the window forces service
   assign cand = is_lvl ? (req & ~mask & (~rirr | svc_hit)) : req;

   always_comb begin
      if (!eff)
         req_d = 1'b0;
      else if (is_lvl)
         req_d = 1'b1;
      else
         req_d = rise | (req & ~grant);
   end

   always_comb begin
      if (grant && is_lvl && !mask)
         rirr_d = 1'b1;
      else if (eoi_clr)
         rirr_d = 1'b0;
      else
         rirr_d = rirr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_q <= 1'b0;
         req   <= 1'b0;
         rirr  <= 1'b0;
      end else begin
         eff_q <= eff;
         req   <= req_d;
         rirr  <= rirr_d;
      end
   end
endmodule

// File: rtl/irq_req_tracker.sv
module irq_req_tracker #(
   parameter int NPIN    = 24,
   parameter int VEC_W   = 8,
   parameter int REG_OUT = 1,
   localparam int PIN_W  = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPIN-1:0]        line_i,
   input  logic [NPIN-1:0]        pol_i,
   input  logic [NPIN-1:0]        trig_level_i,
   input  logic [NPIN-1:0]        mask_i,
   input  logic [NPIN*VEC_W-1:0]  vec_i,
   input  logic                   eoi_valid_i,
   input  logic [VEC_W-1:0]       eoi_vec_i,
   input  logic                   svc_strobe_i,
   input  logic [PIN_W-1:0]       svc_pin_i,
   output logic                   dlv_valid_o,
   output logic [PIN_W-1:0]       dlv_pin_o
);
   if (NPIN < 2 || NPIN > 256) begin : g_bad_npin
      $error("irq_req_tracker: NPIN must lie in 2..256");
   end
   if (VEC_W < 1 || VEC_W > 32) begin : g_bad_vecw
      $error("irq_req_tracker: VEC_W must lie in 1..32");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_regout
      $error("irq_req_tracker: REG_OUT must be 0 or 1");
   end

   logic [NPIN-1:0] cand_v, req_q, rirr_q;
   logic [NPIN-1:0] gnt_oh, eoi_match, eoi_oh;
   logic [PIN_W-1:0] gnt_idx, eoi_idx;
   logic gnt_any, eoi_found, gnt_deliver, svc_ok;

   assign svc_ok = svc_strobe_i & ({1'b0, svc_pin_i} < (PIN_W + 1)'(NPIN));

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      assign eoi_match[i] = eoi_valid_i & (vec_i[i*VEC_W +: VEC_W] == eoi_vec_i);

      irt_line_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (line_i[i]),
         .pol      (pol_i[i]),
         .lvl_mode (trig_level_i[i]),
         .mask     (mask_i[i]),
         .svc_hit  (svc_ok & (svc_pin_i == PIN_W'(i))),
         .grant    (gnt_oh[i]),
         .eoi_clr  (eoi_oh[i]),
         .cand     (cand_v[i]),
         .req      (req_q[i]),
         .rirr     (rirr_q[i])
      );
   end

   irt_lowest_pick #(.N(NPIN), .IW(PIN_W)) u_gnt_pick (
      .req    (cand_v),
      .found  (gnt_any),
      .idx    (gnt_idx),
      .onehot (gnt_oh)
   );

   irt_lowest_pick #(.N(NPIN), .IW(PIN_W)) u_eoi_pick (
      .req    (eoi_match),
      .found  (eoi_found),
      .idx    (eoi_idx),
      .onehot (eoi_oh)
   );

   // a masked edge pin consumes its grant slot but produces no pulse
   assign gnt_deliver = gnt_any & ~mask_i[gnt_idx];

   if (REG_OUT != 0) begin : g_out_reg
      logic             v_q;
      logic [PIN_W-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            p_q <= '0;
         end else begin
            v_q <= gnt_deliver;
            p_q <= gnt_idx;
         end
      end
      assign dlv_valid_o = v_q;
      assign dlv_pin_o   = p_q;
   end else begin : g_out_comb
      assign dlv_valid_o = gnt_deliver;
      assign dlv_pin_o   = gnt_idx;
   end

   logic unused_ok;
   assign unused_ok = eoi_found ^ (|eoi_idx);
endmodule

// File: rtl/irt_chk.sv
module irt_chk #(
   parameter int NPIN    = 24,
   parameter int PIN_W   = 5,
   parameter int REG_OUT = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPIN-1:0]  line_i,
   input logic [NPIN-1:0]  pol_i,
   input logic [NPIN-1:0]  mask_i,
   input logic [NPIN-1:0]  trig_level_i,
   input logic [NPIN-1:0]  cand_v,
   input logic [NPIN-1:0]  gnt_oh,
   input logic             gnt_any,
   input logic [PIN_W-1:0] gnt_idx,
   input logic [NPIN-1:0]  req_q,
   input logic [NPIN-1:0]  rirr_q,
   input logic             dlv_valid_o,
   input logic [PIN_W-1:0] dlv_pin_o
);
   logic [NPIN-1:0]  mask_d, effl_d, mask_ref;
   logic [PIN_W-1:0] gidx_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_d <= '0;
         effl_d <= '0;
         gidx_d <= '0;
      end else begin
         mask_d <= mask_i;
         effl_d <= ~(line_i ^ pol_i);
         gidx_d <= gnt_idx;
      end
   end

   if (REG_OUT != 0) begin : g_ref_reg
      assign mask_ref = mask_d;
   end else begin : g_ref_comb
      assign mask_ref = mask_i;
   end

   // R9
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_oh));

   // R9
   gnt_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_any |-> ((cand_v & ((NPIN'(1) << gnt_idx) - NPIN'(1))) == '0));

   // R12
   dlv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid_o |-> ({1'b0, dlv_pin_o} < (PIN_W + 1)'(NPIN)));

   // R4
   dlv_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid_o |-> !mask_ref[dlv_pin_o]);

   // R5
   rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_any && !mask_i[gnt_idx] && trig_level_i[gnt_idx]) |=> rirr_q[gidx_d]);

   // R3
   edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_any && !trig_level_i[gnt_idx]) |=> !req_q[gidx_d]);

   // R2
   req_low_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q & effl_d) == '0);
endmodule

bind irq_req_tracker irt_chk #(.NPIN(NPIN), .PIN_W(PIN_W), .REG_OUT(REG_OUT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .line_i       (line_i),
   .pol_i        (pol_i),
   .mask_i       (mask_i),
   .trig_level_i (trig_level_i),
   .cand_v       (cand_v),
   .gnt_oh       (gnt_oh),
   .gnt_any      (gnt_any),
   .gnt_idx      (gnt_idx),
   .req_q        (req_q),
   .rirr_q       (rirr_q),
   .dlv_valid_o  (dlv_valid_o),
   .dlv_pin_o    (dlv_pin_o)
);

// File: tb/irq_req_tracker_test.sv
module irq_req_tracker_test;
   localparam int CLK_PERIOD = 10;
   localparam int NPIN  = 24;
   localparam int VEC_W = 8;
   localparam int PIN_W = $clog2(NPIN);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NPIN-1:0] line = '0, pol = '0, trig = '0, mask = '0;
   logic [NPIN*VEC_W-1:0] vec;
   logic eoi_v = 1'b0;
   logic [VEC_W-1:0] eoi_vec = '0;
   logic svc = 1'b0;
   logic [PIN_W-1:0] svc_pin = '0;
   logic dlv_valid;
   logic [PIN_W-1:0] dlv_pin;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int q_pin[$];
   string q_tag[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_req_tracker #(.NPIN(NPIN), .VEC_W(VEC_W), .REG_OUT(1)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_i       (line),
      .pol_i        (pol),
      .trig_level_i (trig),
      .mask_i       (mask),
      .vec_i        (vec),
      .eoi_valid_i  (eoi_v),
      .eoi_vec_i    (eoi_vec),
      .svc_strobe_i (svc),
      .svc_pin_i    (svc_pin),
      .dlv_valid_o  (dlv_valid),
      .dlv_pin_o    (dlv_pin)
   );

   // monitor: every pulse must match the head of the expectation queue
   always @(negedge clk) begin
      if (rst_n && dlv_valid && !done) begin
         checks++;
         if (q_pin.size() == 0) begin
            errors++;
            $display("FAIL R12 unexpected delivery: actual pin=%0d expected none", dlv_pin);
         end else begin
            int p;
            string t;
            p = q_pin.pop_front();
            t = q_tag.pop_front();
            if (int'(dlv_pin) != p) begin
               errors++;
               $display("FAIL %s delivery pin: actual=%0d expected=%0d", t, dlv_pin, p);
            end
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_dlv(input int p, input string t);
      q_pin.push_back(p);
      q_tag.push_back(t);
   endtask

   task automatic check_empty(input string t);
      cyc(8);
      checks++;
      if (q_pin.size() != 0) begin
         errors++;
         $display("FAIL %s missing delivery: actual=none expected pin=%0d", t, q_pin[0]);
         q_pin.delete();
         q_tag.delete();
      end
   endtask

   task automatic send_eoi(input logic [VEC_W-1:0] v);
      eoi_vec = v;
      eoi_v = 1'b1;
      cyc(1);
      eoi_v = 1'b0;
   endtask

   task automatic strobe(input logic [PIN_W-1:0] p);
      svc_pin = p;
      svc = 1'b1;
      cyc(1);
      svc = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NPIN; i++) vec[i*VEC_W +: VEC_W] = VEC_W'(8'h80 + i);
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R12 reset state: no delivery
      checks++;
      if (dlv_valid !== 1'b0) begin
         errors++;
         $display("FAIL R12 reset: actual dlv_valid=%b expected=0", dlv_valid);
      end
      check_empty("R12");

      // R3 edge pin: one delivery per rise, none while held
      line[3] = 1'b1; expect_dlv(3, "R3");
      check_empty("R3");
      line[3] = 1'b0; cyc(2);
      line[3] = 1'b1; expect_dlv(3, "R3");
      check_empty("R3");
      line[3] = 1'b0;

      // R1 polarity inversion makes a low line active
      pol[5] = 1'b1; expect_dlv(5, "R1");
      check_empty("R1");

      // R9 simultaneous rises, lowest first
      line[4] = 1'b1; line[2] = 1'b1;
      expect_dlv(2, "R9"); expect_dlv(4, "R9");
      check_empty("R9");

      // R5 level pin held off by remote-IRR
      trig[7] = 1'b1; vec[7*VEC_W +: VEC_W] = 8'h41;
      line[7] = 1'b1; expect_dlv(7, "R5");
      check_empty("R5");
      // R7 matching EOI with line still high redelivers
      send_eoi(8'h41); expect_dlv(7, "R7");
      check_empty("R7");
      // R2 line dropped before EOI: no redelivery
      line[7] = 1'b0; cyc(2);
      send_eoi(8'h41);
      check_empty("R2");

      // R4 masked edge request discarded
      mask[9] = 1'b1; line[9] = 1'b1;
      check_empty("R4");
      mask[9] = 1'b0;
      check_empty("R4");

      // R6 masked level request held until unmask
      trig[10] = 1'b1; mask[10] = 1'b1; line[10] = 1'b1;
      check_empty("R6");
      mask[10] = 1'b0; expect_dlv(10, "R6");
      check_empty("R6");

      // R7 shared vector: only lowest match released
      trig[12] = 1'b1; trig[14] = 1'b1;
      vec[12*VEC_W +: VEC_W] = 8'h50; vec[14*VEC_W +: VEC_W] = 8'h50;
      line[12] = 1'b1; line[14] = 1'b1;
      expect_dlv(12, "R7"); expect_dlv(14, "R7");
      check_empty("R7");
      send_eoi(8'h50); expect_dlv(12, "R7");
      check_empty("R7");

      // R8 unmatched EOI does nothing
      send_eoi(8'h99);
      check_empty("R8");

      // R11 out-of-range strobe ignored
      strobe(PIN_W'(30));
      check_empty("R11");

      // R10 strobe services a level pin despite remote-IRR
      line[7] = 1'b1; expect_dlv(7, "R10");
      check_empty("R10");
      strobe(PIN_W'(7)); expect_dlv(7, "R10");
      check_empty("R10");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule